// File: doc/BRIEF.md
# Serial Configuration Image Loader

After reset this block reads a 32-byte configuration image from an external serial EEPROM, one byte per request, through a byte-read port. A separate two-wire bus master answers each request with a data byte or with a no-acknowledge flag. The loader checks the image as the bytes arrive. When every check passes, it publishes the descriptor overrides: vendor ID, product ID, device release, serial-number string and length, port count, non-removable bitmap and three attribute bits. When any check fails, it publishes a fixed set of defaults.

Incoming bytes are written into a shadow image and summed on the way. The published output registers hold their defaults from reset. They are written exactly once, either in the COMMIT state from the shadow image or in the FALLBACK state with the defaults. A partially read image is therefore never visible at the outputs.

The sequencer has six states:
- START is the first cycle after reset.
- REQ raises the request for the current address.
- WAIT waits for the response.
- COMMIT and FALLBACK publish the result.
- DONE is terminal.

The transitions are:
- START to REQ.
- REQ to WAIT.
- WAIT to REQ when the byte is good and is not the last one. The address increments.
- WAIT to COMMIT when the last byte matches the running sum.
- WAIT to FALLBACK on a bad byte or a checksum mismatch.
- COMMIT to DONE and FALLBACK to DONE.

Top module: `cfg_image_loader`

## Requirements
- R1: Addresses are requested in ascending order starting at 0, one at a time. `rd_req` is a single-cycle pulse, and the next request is issued only after `rd_done` for the previous one.
- R2: Byte 0 must be 0x40 and byte 1 must be 0x1A. On any other value, no further request is issued, `image_valid` stays 0 and the defaults are published.
- R3: Byte 31 must equal the sum modulo 256 of bytes 0 to 30. On a mismatch, the defaults are published and `image_valid` is 0.
- R4: `rd_nack` at any address stops the load with no further request and publishes the defaults. An absent device that does not acknowledge address 0 gives exactly one request.
- R5: A serial-length byte (byte 24) above 16 stops the load after that byte and publishes the defaults.
- R6: On acceptance, the outputs take these values and `image_valid` is 1:
  - `vendor_id` = {b3,b2}, `product_id` = {b5,b4} and `release_bcd` = {b7,b6}.
  - `serial_str[8i+7:8i]` = byte 8+i, for i from 0 to 15.
  - `serial_len` = byte 24, `port_count` = byte 26 and `removable_map` = byte 28.
  - `port_ind_en` = bit 0 of byte 30, `compound_dev` = bit 1 of byte 30 and `hi_current` = bit 2 of byte 30.
- R7: From reset until `load_done` rises, the outputs show the defaults. The defaults are:
  - vendor 0xC0DE, product 0x0107 and release 0x0100.
  - serial all zero, length 0.
  - port count 7, bitmap 0 and all attribute bits 0.

  The outputs change only in the cycle `load_done` rises and stay stable afterwards.
- R8: `load_done` is sticky until reset, and `image_valid` is 1 only while `load_done` is 1.
- R9: Filler bytes 25, 27 and 29 and bits 7 to 3 of byte 30 have no effect on the outputs, apart from their part in the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | output | 1 | Single-cycle byte-read request |
| rd_addr | output | 5 | Address of the requested byte |
| rd_done | input | 1 | Response strobe for the outstanding request |
| rd_data | input | 8 | Returned byte, valid with rd_done |
| rd_nack | input | 1 | Device did not acknowledge, valid with rd_done |
| vendor_id | output | 16 | Published vendor ID |
| product_id | output | 16 | Published product ID |
| release_bcd | output | 16 | Published device release (BCD) |
| serial_str | output | 128 | Serial characters, character 0 in the low byte |
| serial_len | output | 5 | Number of valid serial characters |
| port_count | output | 8 | Downstream port count |
| removable_map | output | 8 | Non-removable port bitmap |
| port_ind_en | output | 1 | Port indicator support |
| compound_dev | output | 1 | Part of a compound device |
| hi_current | output | 1 | 1 for 500 mA controller current, 0 for 200 mA |
| image_valid | output | 1 | Published values came from the image |
| load_done | output | 1 | Loading finished, outputs final |

## Verification
The hardest situation to reach is a rejection deep in the image with everything before it correct. Examples are a serial length of 17 or a checksum that is off by one, each arriving after 24 or 31 well-formed bytes. Random images never produce these cases by chance. The bench therefore builds a valid image from random content, computes its checksum, and then corrupts exactly one field. It also injects a no-acknowledge at a randomly chosen address. Response latency is randomised on every request so that the request-and-wait handshake is exercised with varying gaps.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    localparam int IMG_BYTES = 32;
    localparam int ADDR_W    = $clog2(IMG_BYTES);
    localparam int SER_MAX   = 16;
    localparam int LEN_W     = $clog2(SER_MAX + 1);

    localparam logic [ADDR_W-1:0] A_SIG_LO = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SIG_HI = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SLEN   = ADDR_W'(24);
    localparam logic [ADDR_W-1:0] A_SUM    = ADDR_W'(IMG_BYTES - 1);

    localparam int OFS_VID   = 2;
    localparam int OFS_PID   = 4;
    localparam int OFS_REL   = 6;
    localparam int OFS_SER   = 8;
    localparam int OFS_SLEN  = 24;
    localparam int OFS_PORTS = 26;
    localparam int OFS_REMOV = 28;
    localparam int OFS_ATTR  = 30;

    localparam logic [7:0] SIG_LO = 8'h40;
    localparam logic [7:0] SIG_HI = 8'h1A;

    typedef enum logic [2:0] {
        ST_START,
        ST_REQ,
        ST_WAIT,
        ST_COMMIT,
        ST_FALLBACK,
        ST_DONE
    } ld_state_t;
endpackage

// File: rtl/cfgl_sum_acc.sv
module cfgl_sum_acc #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_val,
    output logic [DATA_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (add_en)
            acc <= acc + add_val;
    end
endmodule

// File: rtl/cfgl_shadow.sv
module cfgl_shadow #(
    parameter int NBYTES = 32,
    parameter int AW     = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NBYTES*8-1:0] image_flat
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                image_flat[8*g +: 8] <= 8'h00;
            else if (wr_en && wr_addr == AW'(g))
                image_flat[8*g +: 8] <= wr_data;
        end
    end
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
    import cfgl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_done,
    input  logic              rd_nack,
    input  logic [7:0]        rd_data,
    input  logic [7:0]        sum_acc,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              byte_take,
    output logic              sum_add,
    output logic              commit,
    output logic              fallback,
    output logic              load_done
);
    ld_state_t         state, state_nx;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic              bad_byte, at_last;

    always_comb begin
        at_last  = (addr_q == A_SUM);
        bad_byte = rd_nack
                || (addr_q == A_SIG_LO && rd_data != SIG_LO)
                || (addr_q == A_SIG_HI && rd_data != SIG_HI)
                || (addr_q == A_SLEN   && rd_data > 8'(SER_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_START;
            addr_q <= '0;
        end else begin
            state  <= state_nx;
            addr_q <= addr_nx;
        end
    end

    always_comb begin
        state_nx = state;
        addr_nx  = addr_q;
        unique case (state)
            ST_START:    state_nx = ST_REQ;
            ST_REQ:      state_nx = ST_WAIT;
            ST_WAIT: begin
                if (rd_done) begin
                    if (bad_byte)
                        state_nx = ST_FALLBACK;
                    else if (at_last)
                        state_nx = (rd_data == sum_acc) ? ST_COMMIT : ST_FALLBACK;
                    else begin
                        state_nx = ST_REQ;
                        addr_nx  = addr_q + 1'b1;
                    end
                end
            end
            ST_COMMIT:   state_nx = ST_DONE;
            ST_FALLBACK: state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_DONE;
            default:     state_nx = ST_START;
        endcase
    end

    always_comb begin
        rd_req    = (state == ST_REQ);
        rd_addr   = addr_q;
        byte_take = (state == ST_WAIT) && rd_done && !rd_nack;
        sum_add   = byte_take && !at_last;
        commit    = (state == ST_COMMIT);
        fallback  = (state == ST_FALLBACK);
        load_done = (state == ST_DONE);
    end
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfgl_pkg::*;
#(
    parameter logic [15:0] DEF_VID   = 16'hC0DE,
    parameter logic [15:0] DEF_PID   = 16'h0107,
    parameter logic [15:0] DEF_REL   = 16'h0100,
    parameter logic [7:0]  DEF_PORTS = 8'd7,
    parameter logic [7:0]  DEF_REMOV = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic                   rd_req,
    output logic [ADDR_W-1:0]      rd_addr,
    input  logic                   rd_done,
    input  logic [7:0]             rd_data,
    input  logic                   rd_nack,
    output logic [15:0]            vendor_id,
    output logic [15:0]            product_id,
    output logic [15:0]            release_bcd,
    output logic [SER_MAX*8-1:0]   serial_str,
    output logic [LEN_W-1:0]       serial_len,
    output logic [7:0]             port_count,
    output logic [7:0]             removable_map,
    output logic                   port_ind_en,
    output logic                   compound_dev,
    output logic                   hi_current,
    output logic                   image_valid,
    output logic                   load_done
);
    logic                   byte_take, sum_add, commit, fallback;
    logic [7:0]             sum_acc;
    logic [IMG_BYTES*8-1:0] img;
    logic                   unused_bits;

    cfgl_seq u_seq (
        .clk(clk), .rst(rst), .rd_done(rd_done), .rd_nack(rd_nack),
        .rd_data(rd_data), .sum_acc(sum_acc), .rd_req(rd_req),
        .rd_addr(rd_addr), .byte_take(byte_take), .sum_add(sum_add),
        .commit(commit), .fallback(fallback), .load_done(load_done)
    );

    cfgl_sum_acc #(.DATA_W(8)) u_sum (
        .clk(clk), .rst(rst), .add_en(sum_add), .add_val(rd_data), .acc(sum_acc)
    );

    cfgl_shadow #(.NBYTES(IMG_BYTES), .AW(ADDR_W)) u_shadow (
        .clk(clk), .rst(rst), .wr_en(byte_take), .wr_addr(rd_addr),
        .wr_data(rd_data), .image_flat(img)
    );

    assign unused_bits = ^{img[15:0], img[8*25 +: 8], img[8*27 +: 8],
                           img[8*29 +: 8], img[8*OFS_ATTR+3 +: 5],
                           img[8*OFS_SLEN+LEN_W +: 8-LEN_W], img[8*31 +: 8]};

    always_ff @(posedge clk) begin
        if (rst || fallback) begin
            vendor_id     <= DEF_VID;
            product_id    <= DEF_PID;
            release_bcd   <= DEF_REL;
            serial_str    <= '0;
            serial_len    <= '0;
            port_count    <= DEF_PORTS;
            removable_map <= DEF_REMOV;
            port_ind_en   <= 1'b0;
            compound_dev  <= 1'b0;
            hi_current    <= 1'b0;
            image_valid   <= 1'b0;
        end else if (commit) begin
            vendor_id     <= img[8*OFS_VID +: 16];
            product_id    <= img[8*OFS_PID +: 16];
            release_bcd   <= img[8*OFS_REL +: 16];
            serial_str    <= img[8*OFS_SER +: SER_MAX*8];
            serial_len    <= img[8*OFS_SLEN +: LEN_W];
            port_count    <= img[8*OFS_PORTS +: 8];
            removable_map <= img[8*OFS_REMOV +: 8];
            port_ind_en   <= img[8*OFS_ATTR];
            compound_dev  <= img[8*OFS_ATTR+1];
            hi_current    <= img[8*OFS_ATTR+2];
            image_valid   <= 1'b1;
        end
    end
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker
    import cfgl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic              rd_done,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [15:0]       vendor_id,
    input logic [LEN_W-1:0]  serial_len,
    input logic              image_valid,
    input logic              load_done
);
    logic              seen_req, pending;
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_req  <= 1'b0;
            pending   <= 1'b0;
            prev_addr <= '0;
        end else begin
            if (rd_req) begin
                seen_req  <= 1'b1;
                prev_addr <= rd_addr;
                pending   <= 1'b1;
            end else if (rd_done) begin
                pending   <= 1'b0;
            end
        end
    end

    assert_req_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);
    assert_addr_order_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && seen_req) |-> (rd_addr == prev_addr + 1'b1));
    assert_first_addr_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !seen_req) |-> (rd_addr == '0));
    assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !pending);
    assert_quiet_after_done_R2: assert property (@(posedge clk) disable iff (rst)
        load_done |-> !rd_req);
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        load_done |=> load_done);
    assert_valid_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
        image_valid |-> load_done);
    assert_publish_once_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(vendor_id) |-> $rose(load_done));
    assert_len_bound_R5: assert property (@(posedge clk) disable iff (rst)
        image_valid |-> (serial_len <= LEN_W'(SER_MAX)));
endmodule

bind cfg_image_loader cfgl_checker u_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_done(rd_done),
    .rd_addr(rd_addr), .vendor_id(vendor_id), .serial_len(serial_len),
    .image_valid(image_valid), .load_done(load_done)
);

// File: tb/cfg_image_loader_test.sv
module cfg_image_loader_test;
    import cfgl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_req, rd_done, rd_nack, port_ind_en, compound_dev, hi_current, image_valid, load_done;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0] rd_data, port_count, removable_map;
    logic [15:0] vendor_id, product_id, release_bcd;
    logic [SER_MAX*8-1:0] serial_str;
    logic [LEN_W-1:0] serial_len;

    always #10 clk = ~clk;

    cfg_image_loader uut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
        .rd_data(rd_data), .rd_nack(rd_nack), .vendor_id(vendor_id),
        .product_id(product_id), .release_bcd(release_bcd), .serial_str(serial_str),
        .serial_len(serial_len), .port_count(port_count), .removable_map(removable_map),
        .port_ind_en(port_ind_en), .compound_dev(compound_dev), .hi_current(hi_current),
        .image_valid(image_valid), .load_done(load_done)
    );

    logic [7:0] img [IMG_BYTES];
    int nack_at = -1;
    int req_count = 0;
    int order_err = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    // responder: answers each request after 1..4 cycles
    initial begin
        rd_done = 0; rd_nack = 0; rd_data = 0;
        forever begin
            @(negedge clk);
            rd_done = 0; rd_nack = 0;
            if (rd_req && !rst) begin
                if (int'(rd_addr) != req_count) order_err++;
                req_count++;
                repeat (1 + ($urandom % 4)) @(negedge clk);
                rd_done = 1;
                rd_nack = (int'(rd_addr) == nack_at);
                rd_data = rd_nack ? 8'hFF : img[rd_addr];
            end
        end
    end

    function automatic logic [7:0] img_sum();
        logic [7:0] s = 0;
        for (int i = 0; i < IMG_BYTES - 1; i++) s += img[i];
        return s;
    endfunction

    function automatic int exp_reqs();
        for (int a = 0; a < IMG_BYTES; a++) begin
            if (a == nack_at) return a + 1;
            if (a == 0 && img[0] != 8'h40) return 1;
            if (a == 1 && img[1] != 8'h1A) return 2;
            if (a == 24 && img[24] > 8'd16) return 25;
        end
        return IMG_BYTES;
    endfunction

    function automatic bit exp_ok();
        return nack_at < 0 && img[0] == 8'h40 && img[1] == 8'h1A
            && img[24] <= 8'd16 && img[31] == img_sum();
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic make_good(input int slen, input logic [7:0] attr);
        for (int i = 0; i < IMG_BYTES; i++) img[i] = 8'($urandom);
        img[0] = 8'h40; img[1] = 8'h1A;
        for (int i = 0; i < SER_MAX; i++)
            img[8 + i] = (i < slen) ? 8'(8'h30 + ($urandom % 40)) : 8'h00;
        img[24] = 8'(slen);
        img[25] = 0; img[27] = 0; img[29] = 0;
        img[30] = attr;
        img[31] = img_sum();
    endtask

    task automatic check_outputs(input string req);
        logic [127:0] ser;
        bit ok = exp_ok();
        chk(image_valid == ok, ok ? "R6" : req, "image_valid", 128'(image_valid), 128'(ok));
        chk(req_count == exp_reqs(), req, "request count", 128'(req_count), 128'(exp_reqs()));
        chk(order_err == 0, "R1", "address order errors", 128'(order_err), 128'd0);
        if (ok) begin
            for (int i = 0; i < SER_MAX; i++) ser[8*i +: 8] = img[8 + i];
            chk(vendor_id == {img[3], img[2]}, "R6", "vendor_id", 128'(vendor_id), 128'({img[3], img[2]}));
            chk(product_id == {img[5], img[4]}, "R6", "product_id", 128'(product_id), 128'({img[5], img[4]}));
            chk(release_bcd == {img[7], img[6]}, "R6", "release_bcd", 128'(release_bcd), 128'({img[7], img[6]}));
            chk(serial_str == ser, "R6", "serial_str", serial_str, ser);
            chk(serial_len == img[24][4:0], "R6", "serial_len", 128'(serial_len), 128'(img[24]));
            chk({port_count, removable_map} == {img[26], img[28]}, "R6", "ports/removable",
                128'({port_count, removable_map}), 128'({img[26], img[28]}));
            chk({hi_current, compound_dev, port_ind_en} == img[30][2:0], "R9", "attribute bits",
                128'({hi_current, compound_dev, port_ind_en}), 128'(img[30][2:0]));
        end else begin
            chk(vendor_id == 16'hC0DE && product_id == 16'h0107 && release_bcd == 16'h0100,
                req, "default ids", 128'({vendor_id, product_id, release_bcd}), 128'(48'hC0DE_0107_0100));
            chk(serial_str == 0 && serial_len == 0 && port_count == 7 && removable_map == 0
                && {hi_current, compound_dev, port_ind_en} == 0, req, "default fields",
                128'({serial_len, port_count, removable_map}), 128'({5'd0, 8'd7, 8'd0}));
        end
    endtask

    task automatic run_case(input string req);
        int guard = 0;
        rst = 1; req_count = 0; order_err = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!load_done && !image_valid && vendor_id == 16'hC0DE && port_count == 8'd7,
            "R7", "defaults while loading", 128'({load_done, image_valid, vendor_id}), 128'({2'b00, 16'hC0DE}));
        while (!load_done && guard < 2000) begin @(negedge clk); guard++; end
        chk(load_done, "R8", "load_done reached", 128'(load_done), 128'd1);
        repeat (6) @(negedge clk);
        chk(load_done, "R8", "load_done sticky", 128'(load_done), 128'd1);
        check_outputs(req);
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R6 directed and random accepted images
        make_good(9, 8'h05); nack_at = -1; run_case("R6");
        make_good(16, 8'h02); run_case("R6");
        make_good(0, 8'h07); run_case("R6");
        // R9 filler and reserved attribute bits set, checksum recomputed
        make_good(5, 8'hF9); img[25] = 8'hAA; img[27] = 8'h11; img[29] = 8'h80;
        img[31] = img_sum(); run_case("R9");
        // R2 check code faults
        make_good(4, 0); img[0] = 8'h41; run_case("R2");
        make_good(4, 0); img[1] = 8'h1B; run_case("R2");
        // R3 checksum off by one
        make_good(8, 3); img[31] = img[31] + 8'd1; run_case("R3");
        // R5 serial length too large
        make_good(16, 0); img[24] = 8'd17; img[31] = img_sum(); run_case("R5");
        // R4 absent device and random nack position
        make_good(3, 0); nack_at = 0; run_case("R4");
        make_good(3, 0); nack_at = 31; run_case("R4");
        for (int k = 0; k < 4; k++) begin
            make_good(int'($urandom % 17), 8'($urandom % 8));
            nack_at = int'($urandom % 32); run_case("R4");
        end
        nack_at = -1;
        for (int k = 0; k < 6; k++) begin
            make_good(int'($urandom % 17), 8'($urandom));
            run_case("R6");
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule